// File: doc/BRIEF.md
# Stack Push/Pop Multiple-Register Sequencer

This block runs the memory side of a compressed-instruction push or pop of several registers. One `start` pulse hands it a 9-bit list, a direction and the current stack pointer. It then issues one 32-bit word access per cycle on a simple request/ready port, until every listed register has been moved.

For a push, the stack pointer is first lowered by four bytes for each listed entry. The registers are then written upward from the new pointer. For a pop, the words are read upward from the current pointer and written back into the register file. A word popped into the program counter is turned into a branch request instead. At completion the block reports the new stack pointer and the total cycle cost of the operation, which includes the wait cycles it saw.

Top module: `pp_seq`

## Requirements
- R1: List bits [7:0] select registers 0 to 7. Bit 8 selects the link register (read select value 14) on a push and the program counter on a pop.
- R2: A push reports a new stack pointer equal to `sp_in` minus 4 times the number of set list bits.
- R3: A push writes the listed registers in ascending register order to ascending word addresses, starting at the new stack pointer, with the link register last. Every address is word-aligned.
- R4: A pop reads ascending word addresses starting at `sp_in`. It writes each word to the next listed low register in ascending order, with the program-counter word last. It reports `sp_in` plus 4 per word read.
- R5: A pop with bit 8 set raises `branch_en` for the done cycle. `branch_target` carries the last word read, with bit 0 forced to 1 when FORCE_PC_LSB=1 (the default). No other operation raises `branch_en`.
- R6: Exactly one access completes per cycle in which `mem_ready` is high. While `mem_ready` is low, the request and its address are held.
- R7: A push costs (words + 1 + wait cycles).
- R8: A pop costs (words + 2 + wait cycles), plus 3 more when the program counter is popped.
- R9: An empty list makes no memory access and leaves the stack pointer unchanged. It still ends with a done pulse, at a cost of 1 for a push and 2 for a pop.
- R10: `done` is high for exactly one cycle, the cycle after the last access completes. A `start` that arrives while busy is ignored.
- R11: After reset the block is idle: `busy`, `done`, `mem_req`, `reg_wr_en` and `branch_en` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation when idle |
| is_pop | input | 1 | 1 = pop, 0 = push |
| reg_list | input | 9 | Register list; bit 8 = link register or program counter |
| sp_in | input | 32 | Stack pointer at start |
| reg_rd_sel | output | 4 | Register being stored (0-7, or 14 for the link register) |
| reg_rd_data | input | 32 | Value of the selected register |
| reg_wr_en | output | 1 | Low-register write-back strobe |
| reg_wr_idx | output | 3 | Write-back register number |
| reg_wr_data | output | 32 | Write-back value |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid when ready |
| mem_ready | input | 1 | Access completes this cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| sp_out | output | 32 | Updated stack pointer |
| branch_en | output | 1 | Popped program counter needs a jump |
| branch_target | output | 32 | Jump target |
| cycle_cost | output | 16 | Total cycle cost of the last operation |

## Verification
Some rules can be judged cycle by cycle, and the assertions check those on every clock:
- the access address is word-aligned;
- request and address are held during a stall;
- addresses step by four between back-to-back accesses;
- write-backs occur only on completed reads;
- `done` and `branch_en` last one cycle.

Other properties need a reference model of memory and registers, so only the bench scenarios can show them:
- ordering of data in memory and in the registers;
- pointer arithmetic;
- cycle-cost totals under varied stall lengths;
- the empty-list case;
- the ignored second start.

// File: rtl/pp_pkg.sv
package pp_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ACC  = 2'd1,
      ST_DONE = 2'd2
   } pp_state_e;

   localparam int LINK_SEL = 14;
   localparam int RD_SEL_W = 4;
endpackage

// File: rtl/pp_pick.sv
module pp_pick #(
   parameter int N  = 9,
   parameter int IW = $clog2(N)
) (
   input  logic [N-1:0]  mask,
   output logic [IW-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (mask[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/pp_cost.sv
module pp_cost #(
   parameter int CNT_W = 16,
   parameter int NW_W  = 4
) (
   input  logic             pop,
   input  logic             has_pc,
   input  logic [NW_W-1:0]  nwords,
   input  logic [CNT_W-1:0] waits,
   output logic [CNT_W-1:0] cost
);
   localparam logic [CNT_W-1:0] PUSH_BASE = CNT_W'(1);
   localparam logic [CNT_W-1:0] POP_BASE  = CNT_W'(2);
   localparam logic [CNT_W-1:0] PC_EXTRA  = CNT_W'(3);

   logic [CNT_W-1:0] base;
   always_comb begin
      if (pop) base = POP_BASE + (has_pc ? PC_EXTRA : '0);
      else     base = PUSH_BASE;
      cost = base + CNT_W'(nwords) + waits;
   end
endmodule

// File: rtl/pp_pcfix.sv
module pp_pcfix #(
   parameter int DW           = 32,
   parameter bit FORCE_PC_LSB = 1'b1
) (
   input  logic [DW-1:0] raw,
   output logic [DW-1:0] target
);
   generate
      if (FORCE_PC_LSB) begin : g_force
         assign target = {raw[DW-1:1], 1'b1};
      end else begin : g_pass
         assign target = raw;
      end
   endgenerate
endmodule

// File: rtl/pp_seq.sv
module pp_seq
   import pp_pkg::*;
#(
   parameter int LOW_REGS     = 8,
   parameter int AW           = 32,
   parameter int DW           = 32,
   parameter int CNT_W        = 16,
   parameter bit FORCE_PC_LSB = 1'b1,
   localparam int LIST_W      = LOW_REGS + 1,
   localparam int RW          = $clog2(LOW_REGS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                is_pop,
   input  logic [LIST_W-1:0]   reg_list,
   input  logic [AW-1:0]       sp_in,
   output logic [RD_SEL_W-1:0] reg_rd_sel,
   input  logic [DW-1:0]       reg_rd_data,
   output logic                reg_wr_en,
   output logic [RW-1:0]       reg_wr_idx,
   output logic [DW-1:0]       reg_wr_data,
   output logic                mem_req,
   output logic                mem_we,
   output logic [AW-1:0]       mem_addr,
   output logic [DW-1:0]       mem_wdata,
   input  logic [DW-1:0]       mem_rdata,
   input  logic                mem_ready,
   output logic                busy,
   output logic                done,
   output logic [AW-1:0]       sp_out,
   output logic                branch_en,
   output logic [DW-1:0]       branch_target,
   output logic [CNT_W-1:0]    cycle_cost
);
   localparam int IW = $clog2(LIST_W);
   localparam int NW = $clog2(LIST_W + 1);

   generate
      if (LOW_REGS < 2 || LOW_REGS > 8) begin : g_bad_regs
         $error("pp_seq: LOW_REGS must lie in 2..8");
      end
      if (AW < 8 || DW < 8) begin : g_bad_width
         $error("pp_seq: address and data widths must be at least 8");
      end
   endgenerate

   pp_state_e         state_q;
   logic [LIST_W-1:0] mask_q;
   logic              pop_q, has_pc_q;
   logic [AW-1:0]     addr_q, sp_res_q;
   logic [NW-1:0]     nwords_q;
   logic [CNT_W-1:0]  waits_q;
   logic [DW-1:0]     pc_q;

   logic [IW-1:0]     pick_idx;
   logic              cur_extra;
   logic [LIST_W-1:0] mask_next;
   logic [NW-1:0]     n_set;
   logic [AW-1:0]     span;

   pp_pick #(.N(LIST_W), .IW(IW)) u_pick (
      .mask (mask_q),
      .idx  (pick_idx)
   );

   pp_cost #(.CNT_W(CNT_W), .NW_W(NW)) u_cost (
      .pop    (pop_q),
      .has_pc (has_pc_q),
      .nwords (nwords_q),
      .waits  (waits_q),
      .cost   (cycle_cost)
   );

   pp_pcfix #(.DW(DW), .FORCE_PC_LSB(FORCE_PC_LSB)) u_pcfix (
      .raw    (pc_q),
      .target (branch_target)
   );

   assign n_set     = NW'($countones(reg_list));
   assign span      = AW'(n_set) << 2;
   assign mask_next = mask_q & (mask_q - 1'b1);
   assign cur_extra = (pick_idx == IW'(LOW_REGS));

   assign busy        = (state_q != ST_IDLE);
   assign done        = (state_q == ST_DONE);
   assign mem_req     = (state_q == ST_ACC);
   assign mem_we      = ~pop_q;
   assign mem_addr    = addr_q;
   assign mem_wdata   = reg_rd_data;
   assign reg_rd_sel  = cur_extra ? RD_SEL_W'(LINK_SEL) : RD_SEL_W'(pick_idx);
   assign reg_wr_en   = mem_req & mem_ready & pop_q & ~cur_extra;
   assign reg_wr_idx  = pick_idx[RW-1:0];
   assign reg_wr_data = mem_rdata;
   assign sp_out      = sp_res_q;
   assign branch_en   = done & pop_q & has_pc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         mask_q   <= '0;
         pop_q    <= 1'b0;
         has_pc_q <= 1'b0;
         addr_q   <= '0;
         sp_res_q <= '0;
         nwords_q <= '0;
         waits_q  <= '0;
         pc_q     <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  mask_q   <= reg_list;
                  pop_q    <= is_pop;
                  has_pc_q <= reg_list[LIST_W-1];
                  nwords_q <= n_set;
                  waits_q  <= '0;
                  addr_q   <= is_pop ? sp_in : (sp_in - span);
                  sp_res_q <= is_pop ? (sp_in + span) : (sp_in - span);
                  state_q  <= (n_set == '0) ? ST_DONE : ST_ACC;
               end
            end
            ST_ACC: begin
               if (!mem_ready) begin
                  waits_q <= waits_q + 1'b1;
               end else begin
                  mask_q <= mask_next;
                  addr_q <= addr_q + AW'(4);
                  if (pop_q && cur_extra) pc_q <= mem_rdata;
                  if (mask_next == '0) state_q <= ST_DONE;
               end
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/pp_seq_chk.sv
module pp_seq_chk #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mem_req,
   input logic          mem_we,
   input logic          mem_ready,
   input logic [AW-1:0] mem_addr,
   input logic          reg_wr_en,
   input logic          done,
   input logic          busy,
   input logic          branch_en
);
   a_r3_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> mem_addr[1:0] == 2'b00);

   a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

   a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ready) |=> (!mem_req || mem_addr == $past(mem_addr) + AW'(4)));

   a_r4_wb_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |-> (mem_req && mem_ready && !mem_we));

   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r10_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy && !mem_req);

   a_r5_branch_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      branch_en |-> done);
endmodule

bind pp_seq pp_seq_chk #(.AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_ready (mem_ready),
   .mem_addr  (mem_addr),
   .reg_wr_en (reg_wr_en),
   .done      (done),
   .busy      (busy),
   .branch_en (branch_en)
);

// File: tb/pp_seq_tb.sv
module pp_seq_tb;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] LR_VAL = 32'h0000_4A52;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        is_pop = 1'b0;
   logic [8:0]  reg_list = '0;
   logic [31:0] sp_in = '0;
   logic [3:0]  reg_rd_sel;
   logic [31:0] reg_rd_data;
   logic        reg_wr_en;
   logic [2:0]  reg_wr_idx;
   logic [31:0] reg_wr_data;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic        mem_ready = 1'b1;
   logic        busy, done, branch_en;
   logic [31:0] sp_out, branch_target;
   logic [15:0] cycle_cost;

   always #(CLK_PERIOD / 2) clk = ~clk;

   pp_seq u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .is_pop(is_pop),
      .reg_list(reg_list), .sp_in(sp_in),
      .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data),
      .reg_wr_en(reg_wr_en), .reg_wr_idx(reg_wr_idx), .reg_wr_data(reg_wr_data),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
      .busy(busy), .done(done), .sp_out(sp_out),
      .branch_en(branch_en), .branch_target(branch_target),
      .cycle_cost(cycle_cost)
   );

   logic [31:0] mem  [0:1023];
   logic [31:0] emem [0:1023];
   logic [31:0] bregs [0:7];
   logic [31:0] eregs [0:7];
   int wait_w = 0;
   int wcnt = 0;
   int acc_cnt = 0;
   int errors = 0;
   int checks = 0;

   assign reg_rd_data = (reg_rd_sel == 4'd14) ? LR_VAL : bregs[reg_rd_sel[2:0]];
   assign mem_rdata   = mem[mem_addr[11:2]];

   always @(negedge clk) begin
      if (mem_req) begin
         if (wcnt < wait_w) begin mem_ready = 1'b0; wcnt++; end
         else begin mem_ready = 1'b1; wcnt = 0; end
      end else begin
         mem_ready = 1'b1; wcnt = 0;
      end
   end

   always @(posedge clk) begin
      if (mem_req && mem_ready) begin
         acc_cnt <= acc_cnt + 1;
         if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
      end
      if (reg_wr_en) bregs[reg_wr_idx] <= reg_wr_data;
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wait_done();
      int guard = 0;
      while (!done && guard < 500) begin @(negedge clk); guard++; end
   endtask

   // One operation: drive, compute expectations, compare after done
   task automatic run_op(input bit pop, input logic [8:0] lst, input logic [31:0] sp, input int w);
      int n = $countones(lst);
      logic [31:0] a, exp_sp, exp_pc;
      logic [15:0] exp_cost;
      bit match;
      wait_w = w;
      acc_cnt = 0;
      exp_pc = 32'h0;
      a = pop ? sp : sp - 32'(4 * n);
      exp_sp = pop ? sp + 32'(4 * n) : sp - 32'(4 * n);
      for (int i = 0; i < 9; i++) begin
         if (lst[i]) begin
            if (!pop) emem[a[11:2]] = (i == 8) ? LR_VAL : eregs[i];
            else if (i == 8) exp_pc = emem[a[11:2]] | 32'h1;
            else eregs[i] = emem[a[11:2]];
            a = a + 32'd4;
         end
      end
      exp_cost = pop ? 16'(n + 2 + w * n + (lst[8] ? 3 : 0)) : 16'(n + 1 + w * n);
      @(negedge clk);
      start = 1'b1; is_pop = pop; reg_list = lst; sp_in = sp;
      @(negedge clk);
      start = 1'b0;
      wait_done();
      chk(done == 1'b1, "R10 done reached", 32'(done), 32'h1);
      chk(sp_out == exp_sp, pop ? "R4 pop sp" : "R2 push sp", sp_out, exp_sp);
      chk(cycle_cost == exp_cost, pop ? "R8 pop cost" : "R7 push cost", 32'(cycle_cost), 32'(exp_cost));
      chk(branch_en == (pop && lst[8]), "R5 branch flag", 32'(branch_en), 32'(pop && lst[8]));
      if (pop && lst[8]) chk(branch_target == exp_pc, "R5 branch target", branch_target, exp_pc);
      chk(acc_cnt == n, "R6 access count", 32'(acc_cnt), 32'(n));
      @(negedge clk);
      chk(!done, "R10 single done", 32'(done), 32'h0);
      match = 1'b1;
      for (int i = 0; i < 1024; i++) if (mem[i] !== emem[i]) match = 1'b0;
      chk(match, "R3 memory image", 32'(match), 32'h1);
      match = 1'b1;
      for (int i = 0; i < 8; i++) if (bregs[i] !== eregs[i]) match = 1'b0;
      chk(match, "R4 register image", 32'(match), 32'h1);
   endtask

   // pop, list, sp, wait cycles per access
   localparam logic [45:0] VEC [0:5] = '{
      {1'b0, 9'h0FF, 32'h0000_0200, 4'd0},
      {1'b0, 9'h105, 32'h0000_0300, 4'd2},
      {1'b1, 9'h0F0, 32'h0000_01E0, 4'd1},
      {1'b1, 9'h181, 32'h0000_02F4, 4'd0},
      {1'b0, 9'h100, 32'h0000_0400, 4'd3},
      {1'b1, 9'h100, 32'h0000_03FC, 4'd0}
   };

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      for (int i = 0; i < 1024; i++) begin mem[i] = 32'hA500_0000 + 32'(i); emem[i] = mem[i]; end
      for (int i = 0; i < 8; i++) begin bregs[i] = 32'h1000_0000 + 32'(i * 32'h11); eregs[i] = bregs[i]; end
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(!busy && !done && !mem_req && !reg_wr_en && !branch_en, "R11 reset idle",
          {27'h0, busy, done, mem_req, reg_wr_en, branch_en}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !mem_req, "R11 idle after release", 32'(busy), 32'h0);
      // R1 R2 R3 R4 R5 R6 R7 R8 table walk
      for (int v = 0; v < 6; v++) run_op(VEC[v][45], VEC[v][44:36], VEC[v][35:4], int'(VEC[v][3:0]));
      // R9 empty list, push and pop
      run_op(1'b0, 9'h000, 32'h0000_0380, 2);
      run_op(1'b1, 9'h000, 32'h0000_0380, 0);
      // R10 start while busy is ignored
      wait_w = 1;
      acc_cnt = 0;
      for (int i = 0; i < 8; i++) emem[(32'h4E0 >> 2) + i] = eregs[i];
      @(negedge clk);
      start = 1'b1; is_pop = 1'b0; reg_list = 9'h0FF; sp_in = 32'h0000_0500;
      @(negedge clk);
      start = 1'b0;
      repeat (2) @(negedge clk);
      start = 1'b1; is_pop = 1'b1; reg_list = 9'h001; sp_in = 32'h0000_0100;
      @(negedge clk);
      start = 1'b0;
      wait_done();
      chk(sp_out == 32'h0000_04E0, "R10 busy start ignored sp", sp_out, 32'h0000_04E0);
      chk(acc_cnt == 8, "R10 busy start ignored count", 32'(acc_cnt), 32'd8);
      begin
         int extra = 0;
         for (int k = 0; k < 6; k++) begin @(negedge clk); if (done || busy) extra++; end
         chk(extra == 0, "R10 no second run", 32'(extra), 32'h0);
      end
      begin
         bit match = 1'b1;
         for (int i = 0; i < 8; i++) if (bregs[i] !== eregs[i]) match = 1'b0;
         chk(match, "R10 registers untouched", 32'(match), 32'h1);
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule